// File: doc/BRIEF.md
# Frequency Lock Detector with Asymmetric Hysteresis

This block decides whether a clock recovered from serial data runs at the same frequency as a local reference clock. Both clocks arrive already divided to the same nominal rate. Over a fixed measurement window of reference cycles, the block counts edges of the recovered clock and takes the magnitude of the difference from the nominal count. That magnitude is its frequency error in counts. A lock flag is updated from this error once per window.

The hysteresis is asymmetric. A locked detector releases the flag only when the error rises above a fixed wide limit. An unlocked detector raises the flag only when the error falls below a relock limit. An input picks the relock limit from a tight value and a loose value.

The detector also drives an acquisition-source select for the loop. While the flag is low, or while the active-low force input is held low, the loop is steered to acquire on the reference clock. The data phase detector is selected only when the detector is locked and not forced. The recovered-clock count crosses into the reference domain as a Gray code through a synchroniser.

Top module: `freq_lock_detector`

## Requirements
- R1: During reset and after its release, `lock` is 0 and `acq_sel` is 0.
- R2: The recovered-clock count over each window of 2^WIN_LOG2 reference cycles is compared with 2^WIN_LOG2. The first window after reset only captures a baseline and cannot raise `lock`. With matching clocks, `lock` rises at the end of the second window.
- R3: A locked detector clears `lock` when the error exceeds UNLOCK_LIM (32) counts. This applies whether the recovered clock is fast or slow.
- R4: A locked detector keeps `lock` high while the error is at most UNLOCK_LIM counts.
- R5: With `relock_sel` = 0, an unlocked detector sets `lock` only when the error is below RELOCK_NARROW (2) counts.
- R6: With `relock_sel` = 1, an unlocked detector sets `lock` when the error is below RELOCK_WIDE (8) counts. An error from the relock limit up to UNLOCK_LIM leaves an unlocked detector unlocked.
- R7: `lock` changes only on the reference edge that closes a window. Counting reference rising edges from 1 after reset release, that is an edge whose number is a multiple of 2^WIN_LOG2.
- R8: `acq_sel` is 1 (data phase detector) only when `lock` is 1 and `force_ref_n` is 1. Otherwise it is 0 (reference clock).
- R9: Holding `force_ref_n` low has no effect on `lock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; the window timer and all decisions run on it |
| rec_clk | input | 1 | Divided recovered clock being measured |
| rst_n | input | 1 | Active-low reset, asynchronous assert; deasserted synchronously to ref_clk |
| relock_sel | input | 1 | Relock limit select: 0 = narrow limit, 1 = wide limit |
| force_ref_n | input | 1 | Active-low force: when low, acquisition stays on the reference clock |
| lock | output | 1 | Frequency lock flag |
| acq_sel | output | 1 | Acquisition source: 0 = reference clock, 1 = data phase detector |

## Verification
The assertions assume that the recovered clock stays within the modular range of the counter. Its per-window count must lie well inside zero to twice the nominal count, so that the wrapped difference of two samples equals the true count. They also assume that `rst_n` is released away from a reference edge. The Gray-step property further assumes that the recovered-clock counter advances at most once per recovered edge.

The stimulus keeps the recovered clock within 40 counts of a 1024-count window. Reset is released on a falling reference edge. Frequency and select changes are made mid-window, and a settling interval of several windows follows each change, so that every checked decision comes from clean windows.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic {
    ACQ_REFERENCE = 1'b0,
    ACQ_DATA      = 1'b1
  } acq_src_e;

  // magnitude of difference between measured count and its nominal value
  function automatic int unsigned mag_err(input int unsigned measured,
                                          input int unsigned nominal);
    return (measured > nominal) ? (measured - nominal) : (nominal - measured);
  endfunction

  // hysteresis decision: fixed release limit, selectable acquire limit
  function automatic logic next_lock(input logic        locked,
                                     input int unsigned err,
                                     input int unsigned release_lim,
                                     input int unsigned acquire_lim);
    if (locked) return (err <= release_lim);
    else        return (err <  acquire_lim);
  endfunction

endpackage

// File: rtl/lockdet_rec_counter.sv
module lockdet_rec_counter #(
  parameter int CNT_W       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rec_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);

  function automatic logic [CNT_W-1:0] to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // local reset release aligned to rec_clk
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rec_rst_n;

  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end

  assign rec_rst_n = rst_pipe[SYNC_STAGES-1];

  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_next;
  logic [CNT_W-1:0] gray_q;

  assign bin_next = bin_q + 1'b1;

  always_ff @(posedge rec_clk or negedge rec_rst_n) begin
    if (!rec_rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_next;
      gray_q <= to_gray(bin_next);
    end
  end

  assign gray_o = gray_q;

endmodule

// File: rtl/lockdet_gray_sync.sv
module lockdet_gray_sync #(
  parameter int CNT_W       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);

  function automatic logic [CNT_W-1:0] from_gray(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CNT_W-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= gray_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign bin_o = from_gray(stage_q[SYNC_STAGES-1]);

endmodule

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int WIN_LOG2 = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic win_end
);

  logic [WIN_LOG2-1:0] tick_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_q + 1'b1;
  end

  // last reference cycle of the window
  assign win_end = &tick_q;

endmodule

// File: rtl/lockdet_judge.sv
module lockdet_judge
  import lockdet_pkg::*;
#(
  parameter int          WIN_LOG2      = 16,
  parameter int          CNT_W         = 18,
  parameter int unsigned UNLOCK_LIM    = 32,
  parameter int unsigned RELOCK_WIDE   = 8,
  parameter int unsigned RELOCK_NARROW = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic [CNT_W-1:0] cur_bin,
  input  logic             relock_sel,
  output logic             lock_o,
  output logic             primed_o,
  output logic [CNT_W-1:0] err_o
);

  localparam int unsigned WIN = 2 ** WIN_LOG2;

  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] delta;
  logic [CNT_W-1:0] err;
  logic             primed_q;
  logic             lock_q;
  logic             lock_next;
  int unsigned      acquire_lim;

  assign delta       = cur_bin - prev_q;
  assign err         = CNT_W'(mag_err(32'(delta), WIN));
  assign acquire_lim = relock_sel ? RELOCK_WIDE : RELOCK_NARROW;
  assign lock_next   = next_lock(lock_q, 32'(err), UNLOCK_LIM, acquire_lim);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      lock_q   <= 1'b0;
    end else if (win_end) begin
      prev_q   <= cur_bin;
      primed_q <= 1'b1;
      if (primed_q) lock_q <= lock_next;
    end
  end

  assign lock_o   = lock_q;
  assign primed_o = primed_q;
  assign err_o    = err;

endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector
  import lockdet_pkg::*;
#(
  parameter int          WIN_LOG2      = 16,
  parameter int          SYNC_STAGES   = 2,
  parameter int unsigned UNLOCK_LIM    = 32,
  parameter int unsigned RELOCK_WIDE   = 8,
  parameter int unsigned RELOCK_NARROW = 2
) (
  input  logic ref_clk,
  input  logic rec_clk,
  input  logic rst_n,
  input  logic relock_sel,
  input  logic force_ref_n,
  output logic lock,
  output logic acq_sel
);

  localparam int CNT_W = WIN_LOG2 + 2;

  logic [CNT_W-1:0] rec_gray;
  logic [CNT_W-1:0] cur_bin;
  logic [CNT_W-1:0] meas_err;
  logic             win_end;
  logic             primed;
  acq_src_e         acq_src;

  lockdet_rec_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_rec_counter (
    .rec_clk (rec_clk),
    .rst_n   (rst_n),
    .gray_o  (rec_gray)
  );

  lockdet_gray_sync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_gray_sync (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .gray_i  (rec_gray),
    .bin_o   (cur_bin)
  );

  lockdet_window #(.WIN_LOG2(WIN_LOG2)) i_window (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .win_end (win_end)
  );

  lockdet_judge #(
    .WIN_LOG2      (WIN_LOG2),
    .CNT_W         (CNT_W),
    .UNLOCK_LIM    (UNLOCK_LIM),
    .RELOCK_WIDE   (RELOCK_WIDE),
    .RELOCK_NARROW (RELOCK_NARROW)
  ) i_judge (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .win_end    (win_end),
    .cur_bin    (cur_bin),
    .relock_sel (relock_sel),
    .lock_o     (lock),
    .primed_o   (primed),
    .err_o      (meas_err)
  );

  assign acq_src = (lock && force_ref_n) ? ACQ_DATA : ACQ_REFERENCE;
  assign acq_sel = acq_src;

endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int          CNT_W         = 18,
  parameter int unsigned UNLOCK_LIM    = 32,
  parameter int unsigned RELOCK_WIDE   = 8,
  parameter int unsigned RELOCK_NARROW = 2
) (
  input logic             ref_clk,
  input logic             rec_clk,
  input logic             rst_n,
  input logic             relock_sel,
  input logic             force_ref_n,
  input logic             lock,
  input logic             acq_sel,
  input logic             win_end,
  input logic             primed,
  input logic [CNT_W-1:0] meas_err,
  input logic [CNT_W-1:0] rec_gray
);

  int unsigned err_i;
  int unsigned acq_lim;

  assign err_i   = 32'(meas_err);
  assign acq_lim = relock_sel ? RELOCK_WIDE : RELOCK_NARROW;

  AST_LOCK_AT_WINDOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(lock) |-> $past(win_end)); // R7

  AST_DROP_WIDE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && primed && lock && err_i > UNLOCK_LIM) |=> !lock); // R3

  AST_HOLD_INSIDE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && lock && err_i <= UNLOCK_LIM) |=> lock); // R4

  AST_RELOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && primed && !lock && err_i < acq_lim) |=> lock); // R5

  AST_NO_EARLY_RELOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && !lock && err_i >= acq_lim) |=> !lock); // R6

  AST_BASELINE_ONLY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && !primed) |=> !lock); // R2

  AST_ACQ_GATED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!lock || !force_ref_n) |-> !acq_sel); // R8

  AST_GRAY_STEP: assert property (@(posedge rec_clk) disable iff (!rst_n)
    $onehot0(rec_gray ^ $past(rec_gray))); // R2

endmodule

bind freq_lock_detector lockdet_checker #(
  .CNT_W         (CNT_W),
  .UNLOCK_LIM    (UNLOCK_LIM),
  .RELOCK_WIDE   (RELOCK_WIDE),
  .RELOCK_NARROW (RELOCK_NARROW)
) i_lockdet_checker (
  .ref_clk     (ref_clk),
  .rec_clk     (rec_clk),
  .rst_n       (rst_n),
  .relock_sel  (relock_sel),
  .force_ref_n (force_ref_n),
  .lock        (lock),
  .acq_sel     (acq_sel),
  .win_end     (win_end),
  .primed      (primed),
  .meas_err    (meas_err),
  .rec_gray    (rec_gray)
);

// File: tb/test_freq_lock_detector.sv
`timescale 1ns/1ps
module test_freq_lock_detector;

  localparam int WIN_LOG2 = 10;
  localparam int WIN      = 2 ** WIN_LOG2;

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic rst_n = 1'b0;
  logic relock_sel = 1'b0;
  logic force_ref_n = 1'b1;
  logic lock;
  logic acq_sel;

  real rec_half = 10.0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int edge_cnt = 0;
  int r7_bad = 0;
  logic lock_d = 1'b0;

  freq_lock_detector #(.WIN_LOG2(WIN_LOG2)) i_freq_lock_detector (
    .ref_clk     (ref_clk),
    .rec_clk     (rec_clk),
    .rst_n       (rst_n),
    .relock_sel  (relock_sel),
    .force_ref_n (force_ref_n),
    .lock        (lock),
    .acq_sel     (acq_sel)
  );

  always #10 ref_clk = ~ref_clk;
  always begin
    #(rec_half) rec_clk = ~rec_clk;
  end

  // reference edges numbered from 1 after reset release
  always @(posedge ref_clk) begin
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  // R7 monitor: lock may only move on a window-closing edge
  always @(negedge ref_clk) begin
    if (rst_n && (lock !== lock_d) && (edge_cnt % WIN != 0)) r7_bad++;
    lock_d <= lock;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // recovered clock giving WIN+d counts per window
  task automatic set_delta(input int d);
    rec_half = 10240.0 / real'(WIN + d);
  endtask

  task automatic wait_windows(input int n);
    repeat (n * WIN) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic t_reset_and_baseline;
    set_delta(0);
    repeat (5) @(negedge ref_clk);
    chk("R1 lock in reset", lock, 1'b0);
    chk("R1 acq_sel in reset", acq_sel, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);
    chk("R1 lock after release", lock, 1'b0);
    chk("R1 acq_sel after release", acq_sel, 1'b0);
    while (edge_cnt < WIN + 1) @(negedge ref_clk);
    chk("R2 first window is baseline only", lock, 1'b0);
    while (edge_cnt < 2 * WIN - 1) @(negedge ref_clk);
    chk("R2 no lock before second window end", lock, 1'b0);
    @(negedge ref_clk);
    chk("R2 lock at second window end", lock, 1'b1);
    chk("R8 acq_sel data when locked", acq_sel, 1'b1);
  endtask

  task automatic t_hold_inside;
    set_delta(20);
    wait_windows(3);
    chk("R4 hold at +20 counts", lock, 1'b1);
    set_delta(-20);
    wait_windows(3);
    chk("R4 hold at -20 counts", lock, 1'b1);
  endtask

  task automatic t_drop_fast;
    set_delta(40);
    wait_windows(3);
    chk("R3 drop at +40 counts", lock, 1'b0);
    chk("R8 acq_sel reference when unlocked", acq_sel, 1'b0);
  endtask

  task automatic t_narrow_relock;
    relock_sel = 1'b0;
    set_delta(5);
    wait_windows(3);
    chk("R5 narrow limit blocks relock at 5 counts", lock, 1'b0);
  endtask

  task automatic t_wide_relock;
    relock_sel = 1'b1;
    wait_windows(3);
    chk("R6 wide limit relocks at 5 counts", lock, 1'b1);
  endtask

  task automatic t_hysteresis_gap;
    set_delta(40);
    wait_windows(3);
    chk("R3 drop before gap test", lock, 1'b0);
    set_delta(20);
    wait_windows(3);
    chk("R6 stays unlocked at 20 counts", lock, 1'b0);
    relock_sel = 1'b0;
    set_delta(0);
    wait_windows(3);
    chk("R5 narrow relock at 0 counts", lock, 1'b1);
  endtask

  task automatic t_drop_slow;
    set_delta(-40);
    wait_windows(3);
    chk("R3 drop at -40 counts", lock, 1'b0);
    set_delta(0);
    wait_windows(3);
    chk("R5 relock after slow drop", lock, 1'b1);
  endtask

  task automatic t_force;
    force_ref_n = 1'b0;
    repeat (2) @(negedge ref_clk);
    chk("R8 acq_sel reference when forced", acq_sel, 1'b0);
    wait_windows(2);
    chk("R9 force leaves lock high", lock, 1'b1);
    chk("R8 acq_sel still reference when forced", acq_sel, 1'b0);
    force_ref_n = 1'b1;
    repeat (2) @(negedge ref_clk);
    chk("R8 acq_sel data after force release", acq_sel, 1'b1);
    chk("R9 lock after force release", lock, 1'b1);
  endtask

  initial begin
    t_reset_and_baseline();
    t_hold_inside();
    t_drop_fast();
    t_narrow_relock();
    t_wide_relock();
    t_hysteresis_gap();
    t_drop_slow();
    t_force();
    total++;
    if (r7_bad != 0) begin
      bad++;
      $display("FAIL R7 off-window lock changes actual=%0d expected=0", r7_bad);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule